// File: doc/BRIEF.md
# Hybrid Coarse/Fine Digital Pulse-Width Modulator

This block turns a 10-bit duty word into one pulse-width-modulated output with a fixed period of 1024 clocks. The duty word is split in two. The upper five bits are compared against a slow 5-bit counter. The lower five bits pick one stage of a 32-stage one-hot rotating register through a 32:1 selector. The counter advances once for each full turn of the rotating register, so the two sections together resolve every clock of the period. The clock only has to run 32 times faster than the coarse step, and the rotating register stays 32 stages long instead of 1024.

Each section raises its own start and stop events. The two start events are AND-ed to set an output flip-flop, and the two stop events are AND-ed to clear it. A clear beats a set that arrives in the same cycle. The duty word is captured once per period, in the last cycle of that period. A one-cycle period-start pulse lets the surrounding control loop align its updates.

Top module: `hdpwm_core`

## Requirements
- R1: `period_start_o` is high for exactly one cycle in every 1024. The first pulse falls in the first cycle after reset is released, and the pulses repeat every 1024 cycles after that.
- R2: While `rst` is high, `pwm_o` is low.
- R3: For a captured duty D = 32*C + F, where C is `duty_in[9:5]` and F is `duty_in[4:0]`, `pwm_o` is high for exactly D cycles of the period.
- R4: For a nonzero captured duty, `pwm_o` rises in the cycle right after the period-start cycle and stays high without a break.
- R5: A captured duty of 0 keeps `pwm_o` low for the whole period. The set and clear events meet in the period-start cycle, and the clear wins.
- R6: `duty_in` is sampled only in the last cycle of a period, and the value takes effect from the next period-start cycle. Any value held earlier in the period has no effect on the output.
- R7: A captured duty of 1023 gives a high time of 1023 cycles. The output is low only in the period-start cycle.
- R8: The first period after reset uses a duty of 0, whatever `duty_in` holds.
- R9: Within one period, `pwm_o` has at most one rising edge and at most one falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| duty_in | input | 10 | Duty word; bits 9:5 are the coarse part, bits 4:0 the fine part |
| pwm_o | output | 1 | Modulated output, driven from a flip-flop |
| period_start_o | output | 1 | One-cycle pulse in the first cycle of each period |

## Verification
The bench stresses the points where the two sections hand over to each other. Fine values of 0 and 31 and the coarse boundaries 31, 32 and 33 would show a design that advances the counter one stage early or late; such a design gives pulse widths that are off by 32 or by one. The extremes 0 and 1023 expose a wrong set/clear priority: a design that got it wrong would emit a one-cycle sliver at zero duty, or would fail to drop low for the start cycle at full duty. The bench also changes the duty word mid-period, twice within a single period. A design that does not hold the word until the period boundary would then cut the pulse short or show two edges in one period.

// File: rtl/hdpwm_pkg.sv
package hdpwm_pkg;

    localparam int DEF_COARSE_W = 5;
    localparam int DEF_FINE_W   = 5;

    // Requests into the output flip-flop, already combined across sections.
    typedef struct packed {
        logic set_ev;
        logic clr_ev;
    } sr_req_t;

    typedef enum logic {
        PWM_LOW  = 1'b0,
        PWM_HIGH = 1'b1
    } pwm_lvl_t;

    function automatic int unsigned period_len(int unsigned cw, int unsigned fw);
        return 32'd1 << (cw + fw);
    endfunction

endpackage

// File: rtl/hdpwm_ring.sv
module hdpwm_ring #(
    parameter int FINE_W = hdpwm_pkg::DEF_FINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FINE_W-1:0] sel,
    output logic              wrap,
    output logic              start_tap,
    output logic              sel_tap
);
    localparam int STAGES = 1 << FINE_W;

    logic [STAGES-1:0] taps;
    logic              last_d;

    // One-hot token circulating through registered stages, one stage per clock.
    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) taps[i] <= 1'b1;
                    else     taps[i] <= taps[STAGES-1];
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) taps[i] <= 1'b0;
                    else     taps[i] <= taps[i-1];
                end
            end
        end
    endgenerate

    // Registered copy of the final stage marks the start of each revolution.
    always_ff @(posedge clk) begin
        if (rst) last_d <= 1'b1;
        else     last_d <= taps[STAGES-1];
    end

    assign wrap      = taps[STAGES-1];
    assign start_tap = last_d;
    assign sel_tap   = taps[sel];

endmodule

// File: rtl/hdpwm_coarse.sv
module hdpwm_coarse #(
    parameter int COARSE_W = hdpwm_pkg::DEF_COARSE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                advance,
    input  logic [COARSE_W-1:0] match_val,
    output logic                zero_hit,
    output logic                val_hit,
    output logic                at_last
);
    logic [COARSE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (advance) cnt <= cnt + 1'b1;
    end

    assign zero_hit = (cnt == '0);
    assign val_hit  = (cnt == match_val);
    assign at_last  = &cnt;

endmodule

// File: rtl/hdpwm_srff.sv
module hdpwm_srff
    import hdpwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sr_req_t req,
    output logic    q
);
    pwm_lvl_t lvl;

    // Clear outranks set when both land in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)             lvl <= PWM_LOW;
        else if (req.clr_ev) lvl <= PWM_LOW;
        else if (req.set_ev) lvl <= PWM_HIGH;
    end

    assign q = (lvl == PWM_HIGH);

endmodule

// File: rtl/hdpwm_core.sv
module hdpwm_core
    import hdpwm_pkg::*;
#(
    parameter int COARSE_W = DEF_COARSE_W,
    parameter int FINE_W   = DEF_FINE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [COARSE_W+FINE_W-1:0] duty_in,
    output logic                       pwm_o,
    output logic                       period_start_o
);
    localparam int DUTY_W = COARSE_W + FINE_W;

    logic [DUTY_W-1:0] duty_q;
    logic              ring_wrap, ring_start, ring_sel;
    logic              cnt_zero, cnt_match, cnt_last;
    sr_req_t           req;

    hdpwm_ring #(.FINE_W(FINE_W)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .sel       (duty_q[FINE_W-1:0]),
        .wrap      (ring_wrap),
        .start_tap (ring_start),
        .sel_tap   (ring_sel)
    );

    hdpwm_coarse #(.COARSE_W(COARSE_W)) u_coarse (
        .clk       (clk),
        .rst       (rst),
        .advance   (ring_wrap),
        .match_val (duty_q[DUTY_W-1:FINE_W]),
        .zero_hit  (cnt_zero),
        .val_hit   (cnt_match),
        .at_last   (cnt_last)
    );

    // Capture the duty word in the final cycle of the period.
    always_ff @(posedge clk) begin
        if (rst)                        duty_q <= '0;
        else if (ring_wrap && cnt_last) duty_q <= duty_in;
    end

    always_comb begin
        req.set_ev = cnt_zero  & ring_start;
        req.clr_ev = cnt_match & ring_sel;
    end

    hdpwm_srff u_sr (
        .clk (clk),
        .rst (rst),
        .req (req),
        .q   (pwm_o)
    );

    assign period_start_o = req.set_ev;

endmodule

// File: rtl/hdpwm_chk.sv
module hdpwm_chk #(
    parameter int COARSE_W = hdpwm_pkg::DEF_COARSE_W,
    parameter int FINE_W   = hdpwm_pkg::DEF_FINE_W
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       pwm,
    input logic                       period_start,
    input logic [COARSE_W+FINE_W-1:0] duty_q
);
    localparam int DW  = COARSE_W + FINE_W;
    localparam int LEN = int'(hdpwm_pkg::period_len(COARSE_W, FINE_W));

    logic [DW:0]   gap;
    logic [DW:0]   hi_run;
    logic [DW-1:0] cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap    <= '0;
            hi_run <= '0;
            cap    <= '0;
        end else begin
            gap    <= period_start ? (DW+1)'(1) : gap + 1'b1;
            hi_run <= pwm ? hi_run + 1'b1 : '0;
            if (period_start) cap <= duty_q;
        end
    end

    a_r1_period_spacing: assert property (@(posedge clk) disable iff (rst)
        period_start |-> (gap == '0 || gap == (DW+1)'(LEN)));
    a_r1_no_late_start: assert property (@(posedge clk) disable iff (rst)
        !period_start |-> (gap < (DW+1)'(LEN)));
    a_r4_rise_after_start: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm) |-> $past(period_start));
    a_r5_zero_duty_low: assert property (@(posedge clk) disable iff (rst)
        (period_start && duty_q == '0) |=> !pwm);
    a_r6_duty_held: assert property (@(posedge clk) disable iff (rst)
        !$stable(duty_q) |-> period_start);
    a_r3_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $fell(pwm) |-> (hi_run == {1'b0, cap}));

endmodule

bind hdpwm_core hdpwm_chk #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pwm          (pwm_o),
    .period_start (period_start_o),
    .duty_q       (duty_q)
);

// File: tb/hdpwm_core_tb.sv
module hdpwm_core_tb;
    localparam int N = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] duty_in = 10'd700;
    logic       pwm_o, period_start_o;

    int n_cmp = 0, n_bad = 0;
    int mq = 0, dcur = 0;
    int hi = 0, rises = 0, falls = 0, pidx = 0;
    logic prev_pwm = 1'b0;
    int r6_idx = -1, r6_val = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hdpwm_core u_dut (
        .clk(clk), .rst(rst), .duty_in(duty_in),
        .pwm_o(pwm_o), .period_start_o(period_start_o)
    );

    // Behavioural reference: phase within period and duty in force.
    always @(posedge clk) begin
        if (rst) begin
            mq = 0; dcur = 0;
        end else begin
            if (mq == N-1) dcur = duty_in;
            mq = (mq + 1) % N;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (phase %0d period %0d)", tag, act, exp, mq, pidx);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                chk("R2 pwm low in reset", int'(pwm_o), 0);
            end else begin
                chk("R1 period start", int'(period_start_o), (mq == 0) ? 1 : 0);
                chk("R3 pwm level", int'(pwm_o), (mq >= 1 && mq <= dcur) ? 1 : 0);
                if (mq == 1) chk("R4 rise after start", int'(pwm_o), (dcur > 0) ? 1 : 0);
                if (pwm_o && !prev_pwm) rises++;
                if (!pwm_o && prev_pwm) falls++;
                if (mq >= 1 && pwm_o) hi++;
                if (mq == N-1) begin
                    if (pidx == 0)        chk("R8 first period width", hi, 0);
                    else if (dcur == 0)    chk("R5 zero duty width", hi, 0);
                    else if (dcur == N-1)  chk("R7 full duty width", hi, N-1);
                    else                   chk("R3 pulse width", hi, dcur);
                    if (pidx == r6_idx)    chk("R6 last sampled value used", hi, r6_val);
                    chk("R9 single rise", int'(rises <= 1), 1);
                    chk("R9 single fall", int'(falls <= 1), 1);
                    hi = 0; rises = 0;
                    falls = (!pwm_o && prev_pwm) ? 0 : 0;
                    pidx++;
                end
                if (mq == 0) falls = 0;
            end
            prev_pwm = pwm_o;
        end
    end

    task automatic wait_phase(input int p);
        do @(negedge clk); while (mq != p);
    endtask

    initial begin
        int vals[9] = '{1, 31, 32, 33, 512, 1023, 0, 1000, 2};
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        for (int i = 0; i < 9; i++) begin
            wait_phase(500);
            duty_in = 10'(vals[i]);
        end
        // Two changes inside one period: only the value present at the end counts.
        wait_phase(500);
        duty_in = 10'd5;
        wait_phase(900);
        duty_in = 10'd40;
        r6_val = 40;
        r6_idx = pidx + 1;
        wait_phase(N-1);
        wait_phase(N-1);
        wait_phase(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule